// File: doc/BRIEF.md
# Dual-Bus Maskable Interrupt Aggregator

This block gathers the interrupt sources of a bridge that joins two independent buses and turns them into two interrupt requests, one per bus. The primary request collects the primary doorbell bits, a subsystem event and the outbound message queue non-empty flag. The secondary request collects the secondary doorbell bits, a set of page-boundary translation events, a wake event for a return to full power, and the inbound message queue non-empty flag. Each request is an active-low open-drain line. The block only produces an enable for a low drive (1 = pull the line low), and an external resistor pulls the line high.

Every source has a status bit and a mask bit. The event sources are sticky: a one-cycle set pulse sets them and a write-one-to-clear pulse clears them. The two queue sources are not stored. Their status bit mirrors the queue flag. The mask bits are written through separate set and clear ports. Reset masks every source. A request is raised while any of its side's sources has status 1 and mask 0. The drive enable is registered so the pin never glitches.

Top module: `irq_dual_aggregator`

## Requirements
- R1: A set pulse on a primary doorbell bit (p_evt_set[15:0]) sets that status bit on the next clock edge. When that bit is unmasked, p_irq_drive_low goes to 1 one edge later.
- R2: A set pulse on p_evt_set[16] (subsystem event) sets p_status[16] and, when that bit is unmasked, raises p_irq_drive_low in the same way as R1.
- R3: p_status[17] equals p_queue_nempty at all times and is never latched. When the flag is 1 and unmasked, p_irq_drive_low is 1 one edge later. It returns to 0 one edge after the flag drops, provided no other primary source is active.
- R4: The secondary doorbell bits (s_evt_set[15:0]) and the page-boundary events (s_evt_set[23:16]) set s_status[23:0]. s_status[25] mirrors s_queue_nempty. Any of these, while unmasked, drives s_irq_drive_low to 1 with the same timing as R1 and R3.
- R5: pwr_state uses the encoding D0=0, D1=1, D2=2, D3=3. A clock edge at which the state registered on the previous edge was D1 or D2 and pwr_state is D0 sets s_status[24]. A move from D3 to D0, or any other move, leaves s_status[24] unchanged.
- R6: A source whose mask bit is 1 still records its status but never causes its side's drive enable. After reset all status bits are 0, all mask bits are 1 and both drive enables are 0.
- R7: A clear pulse on a sticky bit (p_evt_clr, s_evt_clr, same bit layout, with s_evt_clr[24] for the wake event) clears it on the next edge. A set and a clear on the same bit in the same cycle leave the bit set.
- R8: A drive enable returns to 0 one edge after the last unmasked source of its side is cleared or emptied.
- R9: The two sides are independent. Primary sources never affect s_irq_drive_low, and secondary sources never affect p_irq_drive_low.
- R10: A mask clear pulse unmasks a bit and a mask set pulse masks it. Both take effect on the next edge, and set wins when both arrive together. The primary mask layout matches p_status, and the secondary mask layout matches s_status.

Ports and widths are given at the default parameters, DB_W=16 and PAGES=8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p_evt_set | input | 17 | Primary sticky set pulses: doorbell [15:0], subsystem [16] |
| p_evt_clr | input | 17 | Primary write-one-to-clear pulses, same layout |
| p_queue_nempty | input | 1 | Outbound message queue holds an entry |
| s_evt_set | input | 24 | Secondary set pulses: doorbell [15:0], pages [23:16] |
| s_evt_clr | input | 25 | Secondary clear pulses: doorbell, pages, wake [24] |
| s_queue_nempty | input | 1 | Inbound message queue holds an entry |
| pwr_state | input | 2 | Current power state, D0=0..D3=3 |
| p_mask_set | input | 18 | Primary mask set pulses (layout of p_status) |
| p_mask_clr | input | 18 | Primary mask clear pulses |
| s_mask_set | input | 26 | Secondary mask set pulses (layout of s_status) |
| s_mask_clr | input | 26 | Secondary mask clear pulses |
| p_status | output | 18 | Primary status: sticky [16:0], queue [17] |
| p_mask | output | 18 | Primary mask bits |
| s_status | output | 26 | Secondary status: sticky [24:0], queue [25] |
| s_mask | output | 26 | Secondary mask bits |
| p_irq_drive_low | output | 1 | 1 = pull the primary interrupt line low |
| s_irq_drive_low | output | 1 | 1 = pull the secondary interrupt line low |

## Verification
The hardest case to reach is the wake event. It needs the power state to sit in D1 or D2 for at least one edge and then step to D0, and it must be told apart from the D3-to-D0 move that must not fire. The stimulus holds pwr_state at each value for a whole step so that the registered previous state settles, and it walks D1→D0 and D3→D0 in turn. The other hard case is a set and a clear landing on the same bit in the same cycle. The stimulus first clears the bit and then applies both pulses at once, so that the bit reads 1 only because the set won.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    PWR_D0 = 2'd0,
    PWR_D1 = 2'd1,
    PWR_D2 = 2'd2,
    PWR_D3 = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_pulse,
  input  logic [W-1:0] clr_pulse,
  output logic [W-1:0] status
);
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_pulse) | set_pulse;
  end

  // R7
  sticky_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_pulse) |=> ((status & $past(set_pulse)) == $past(set_pulse)));

  // R7
  sticky_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clr_pulse & ~set_pulse)) |=> ((status & $past(clr_pulse & ~set_pulse)) == '0));

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((set_pulse == '0) && (clr_pulse == '0)) |=> $stable(status));
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] mask_set,
  input  logic [W-1:0] mask_clr,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst) mask <= '1;
    else     mask <= (mask & ~mask_clr) | mask_set;
  end

  // R10
  mask_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|mask_set) |=> ((mask & $past(mask_set)) == $past(mask_set)));

  // R10
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (|(mask_clr & ~mask_set)) |=> ((mask & $past(mask_clr & ~mask_set)) == '0));
endmodule

// File: rtl/irq_pm_detect.sv
module irq_pm_detect
  import irq_agg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pwr_state,
  output logic       wake_pulse
);
  pwr_state_e cur_state;
  pwr_state_e prev_state;

  assign cur_state = pwr_state_e'(pwr_state);

  always_ff @(posedge clk) begin
    if (rst) prev_state <= PWR_D0;
    else     prev_state <= cur_state;
  end

  always_comb begin
    wake_pulse = 1'b0;
    if ((prev_state == PWR_D1) || (prev_state == PWR_D2))
      wake_pulse = (cur_state == PWR_D0);
  end
endmodule

// File: rtl/irq_side_drive.sv
module irq_side_drive #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status,
  input  logic [W-1:0] mask,
  output logic         drive_low
);
  logic req;

  assign req = |(status & ~mask);

  always_ff @(posedge clk) begin
    if (rst) drive_low <= 1'b0;
    else     drive_low <= req;
  end
endmodule

// File: rtl/irq_dual_aggregator.sv
module irq_dual_aggregator #(
  parameter int DB_W  = 16,
  parameter int PAGES = 8,
  localparam int PSW  = DB_W + 1,
  localparam int PMW  = PSW + 1,
  localparam int SSETW = DB_W + PAGES,
  localparam int SSW  = SSETW + 1,
  localparam int SMW  = SSW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [PSW-1:0] p_evt_set,
  input  logic [PSW-1:0] p_evt_clr,
  input  logic           p_queue_nempty,
  input  logic [SSETW-1:0] s_evt_set,
  input  logic [SSW-1:0] s_evt_clr,
  input  logic           s_queue_nempty,
  input  logic [1:0]     pwr_state,
  input  logic [PMW-1:0] p_mask_set,
  input  logic [PMW-1:0] p_mask_clr,
  input  logic [SMW-1:0] s_mask_set,
  input  logic [SMW-1:0] s_mask_clr,
  output logic [PMW-1:0] p_status,
  output logic [PMW-1:0] p_mask,
  output logic [SMW-1:0] s_status,
  output logic [SMW-1:0] s_mask,
  output logic           p_irq_drive_low,
  output logic           s_irq_drive_low
);
  logic [PSW-1:0] p_sticky;
  logic [SSW-1:0] s_sticky;
  logic [SSW-1:0] s_set_all;
  logic           wake_pulse;

  irq_pm_detect u_pm (
    .clk        (clk),
    .rst        (rst),
    .pwr_state  (pwr_state),
    .wake_pulse (wake_pulse)
  );

  assign s_set_all = {wake_pulse, s_evt_set};

  irq_sticky_bank #(.W(PSW)) u_p_sticky (
    .clk (clk), .rst (rst),
    .set_pulse (p_evt_set), .clr_pulse (p_evt_clr),
    .status (p_sticky)
  );

  irq_sticky_bank #(.W(SSW)) u_s_sticky (
    .clk (clk), .rst (rst),
    .set_pulse (s_set_all), .clr_pulse (s_evt_clr),
    .status (s_sticky)
  );

  assign p_status = {p_queue_nempty, p_sticky};
  assign s_status = {s_queue_nempty, s_sticky};

  irq_mask_bank #(.W(PMW)) u_p_mask (
    .clk (clk), .rst (rst),
    .mask_set (p_mask_set), .mask_clr (p_mask_clr),
    .mask (p_mask)
  );

  irq_mask_bank #(.W(SMW)) u_s_mask (
    .clk (clk), .rst (rst),
    .mask_set (s_mask_set), .mask_clr (s_mask_clr),
    .mask (s_mask)
  );

  irq_side_drive #(.W(PMW)) u_p_drive (
    .clk (clk), .rst (rst),
    .status (p_status), .mask (p_mask),
    .drive_low (p_irq_drive_low)
  );

  irq_side_drive #(.W(SMW)) u_s_drive (
    .clk (clk), .rst (rst),
    .status (s_status), .mask (s_mask),
    .drive_low (s_irq_drive_low)
  );

  // R1
  p_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(p_status & ~p_mask)) |=> p_irq_drive_low);

  // R8
  p_release_chk: assert property (@(posedge clk) disable iff (rst)
    p_irq_drive_low |-> $past(|(p_status & ~p_mask)));

  // R9
  s_release_chk: assert property (@(posedge clk) disable iff (rst)
    s_irq_drive_low |-> $past(|(s_status & ~s_mask)));

  // R5
  wake_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (($past(pwr_state) == 2'd1) || ($past(pwr_state) == 2'd2))
      && (pwr_state == 2'd0)) |=> s_status[SSW-1]);

  // R6
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!p_irq_drive_low && !s_irq_drive_low && (&p_mask) && (&s_mask)
             && (p_sticky == '0) && (s_sticky == '0)));
endmodule

// File: tb/irq_dual_aggregator_tb_top.sv
`timescale 1ns/1ps
module irq_dual_aggregator_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [16:0] p_evt_set = '0, p_evt_clr = '0;
  logic        p_queue_nempty = 1'b0;
  logic [23:0] s_evt_set = '0;
  logic [24:0] s_evt_clr = '0;
  logic        s_queue_nempty = 1'b0;
  logic [1:0]  pwr_state = 2'd0;
  logic [17:0] p_mask_set = '0, p_mask_clr = '0;
  logic [25:0] s_mask_set = '0, s_mask_clr = '0;
  logic [17:0] p_status, p_mask;
  logic [25:0] s_status, s_mask;
  logic        p_irq_drive_low, s_irq_drive_low;

  irq_dual_aggregator dut_i (
    .clk (clk), .rst (rst),
    .p_evt_set (p_evt_set), .p_evt_clr (p_evt_clr), .p_queue_nempty (p_queue_nempty),
    .s_evt_set (s_evt_set), .s_evt_clr (s_evt_clr), .s_queue_nempty (s_queue_nempty),
    .pwr_state (pwr_state),
    .p_mask_set (p_mask_set), .p_mask_clr (p_mask_clr),
    .s_mask_set (s_mask_set), .s_mask_clr (s_mask_clr),
    .p_status (p_status), .p_mask (p_mask), .s_status (s_status), .s_mask (s_mask),
    .p_irq_drive_low (p_irq_drive_low), .s_irq_drive_low (s_irq_drive_low)
  );

  typedef struct packed {
    logic [16:0] pset;
    logic [16:0] pclr;
    logic [23:0] sset;
    logic [24:0] sclr;
    logic        pq;
    logic        sq;
    logic [1:0]  pwr;
    logic        ep;
    logic        es;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{17'h00001, 17'h0,     24'h0,      25'h0,       1'b0, 1'b0, 2'd0, 1'b1, 1'b0}, // R1 doorbell
    '{17'h0,     17'h00001, 24'h0,      25'h0,       1'b0, 1'b0, 2'd0, 1'b0, 1'b0}, // R8 cleared
    '{17'h0,     17'h0,     24'h000020, 25'h0,       1'b0, 1'b0, 2'd0, 1'b0, 1'b1}, // R4 doorbell
    '{17'h0,     17'h0,     24'h0,      25'h0000020, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0}, // R8
    '{17'h0,     17'h0,     24'h0,      25'h0,       1'b1, 1'b0, 2'd0, 1'b1, 1'b0}, // R3 queue
    '{17'h0,     17'h0,     24'h0,      25'h0,       1'b0, 1'b0, 2'd0, 1'b0, 1'b0}, // R3 drained
    '{17'h0,     17'h0,     24'h0,      25'h0,       1'b0, 1'b1, 2'd0, 1'b0, 1'b1}, // R4 queue
    '{17'h0,     17'h0,     24'h0,      25'h0,       1'b0, 1'b0, 2'd0, 1'b0, 1'b0}, // R4 drained
    '{17'h10000, 17'h0,     24'h0,      25'h0,       1'b0, 1'b0, 2'd0, 1'b1, 1'b0}, // R2 subsystem
    '{17'h0,     17'h10000, 24'h0,      25'h0,       1'b0, 1'b0, 2'd0, 1'b0, 1'b0}, // R7 clear
    '{17'h10000, 17'h10000, 24'h0,      25'h0,       1'b0, 1'b0, 2'd0, 1'b1, 1'b0}, // R7 set wins
    '{17'h0,     17'h10000, 24'h0,      25'h0,       1'b0, 1'b0, 2'd0, 1'b0, 1'b0}, // R7
    '{17'h0,     17'h0,     24'h010000, 25'h0,       1'b0, 1'b0, 2'd0, 1'b0, 1'b1}, // R4 page
    '{17'h0,     17'h0,     24'h0,      25'h0010000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0}, // R4
    '{17'h0,     17'h0,     24'h0,      25'h0,       1'b0, 1'b0, 2'd1, 1'b0, 1'b0}, // R5 to D1
    '{17'h0,     17'h0,     24'h0,      25'h0,       1'b0, 1'b0, 2'd0, 1'b0, 1'b1}, // R5 D1->D0
    '{17'h0,     17'h0,     24'h0,      25'h1000000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0}, // R7 wake clr
    '{17'h0,     17'h0,     24'h0,      25'h0,       1'b0, 1'b0, 2'd3, 1'b0, 1'b0}, // R5 to D3
    '{17'h0,     17'h0,     24'h0,      25'h0,       1'b0, 1'b0, 2'd0, 1'b0, 1'b0}, // R5 D3->D0
    '{17'h00008, 17'h0,     24'h0,      25'h0,       1'b0, 1'b1, 2'd0, 1'b1, 1'b1}, // R9 both
    '{17'h0,     17'h00008, 24'h0,      25'h0,       1'b0, 1'b0, 2'd0, 1'b0, 1'b0}  // R9 R8
  };

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_pulses();
    p_evt_set = '0; p_evt_clr = '0; s_evt_set = '0; s_evt_clr = '0;
    p_mask_set = '0; p_mask_clr = '0; s_mask_set = '0; s_mask_clr = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R6 reset p drive", p_irq_drive_low, 0);
    check("R6 reset s drive", s_irq_drive_low, 0);
    check("R6 reset p mask", p_mask, 32'h3FFFF);
    check("R6 reset s mask", s_mask, 32'h3FFFFFF);
    check("R6 reset p status", p_status, 0);
    check("R6 reset s status", s_status, 0);

    // R6 masked source records status but does not drive
    p_evt_set = 17'h00004;
    @(negedge clk); clear_pulses();
    @(negedge clk);
    check("R6 masked status", p_status, 32'h4);
    check("R6 masked no drive", p_irq_drive_low, 0);
    // R10 unmask bit 2
    p_mask_clr = 18'h4;
    @(negedge clk); clear_pulses();
    check("R10 unmasked", p_mask, 32'h3FFFB);
    @(negedge clk);
    check("R10 drive after unmask", p_irq_drive_low, 1);
    // R10 set and clear together: set wins
    p_mask_set = 18'h4; p_mask_clr = 18'h4;
    @(negedge clk); clear_pulses();
    check("R10 set wins", p_mask, 32'h3FFFF);
    @(negedge clk);
    check("R6 remask release", p_irq_drive_low, 0);
    p_evt_clr = 17'h00004;
    @(negedge clk); clear_pulses();
    check("R7 clear masked bit", p_status, 0);

    // R3 queue status mirrors the flag without a clock
    p_queue_nempty = 1'b1; #1;
    check("R3 mirror high", p_status[17], 1);
    p_queue_nempty = 1'b0; #1;
    check("R3 mirror low", p_status[17], 0);

    // unmask every source
    p_mask_clr = '1; s_mask_clr = '1;
    @(negedge clk); clear_pulses();
    check("R10 all unmasked p", p_mask, 0);
    check("R10 all unmasked s", s_mask, 0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      p_evt_set = VECS[i].pset; p_evt_clr = VECS[i].pclr;
      s_evt_set = VECS[i].sset; s_evt_clr = VECS[i].sclr;
      p_queue_nempty = VECS[i].pq; s_queue_nempty = VECS[i].sq;
      pwr_state = VECS[i].pwr;
      @(negedge clk); clear_pulses();
      @(negedge clk);
      check($sformatf("R1 R2 R3 R7 R8 table step %0d p drive", i), p_irq_drive_low, VECS[i].ep);
      check($sformatf("R4 R5 R9 table step %0d s drive", i), s_irq_drive_low, VECS[i].es);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule